// File: doc/BRIEF.md
# Multi-Level Priority Interrupt Arbiter

This block sits on the processor side of a vectored interrupt system with eight priority levels. Level 0 is the most urgent. Levels 0 to 3 are driven by peripheral request lines. Each of these levels has its own grant output, and several devices can share one level by passing an enable chain among themselves. Levels 4 to 7 are raised by software strobes. The arbiter keeps a stack of levels that are in service. Only a level strictly more urgent than the most urgent level in service may interrupt, so service nests and a more urgent level always preempts a less urgent one.

Arbitration happens only on a bus sync pulse, and only while the system is enabled. For a hardware level, the arbiter raises that level's grant and holds it until the device places its six-bit trap vector on the vector bus. The vector must fall in the window octal 40 to 77. The arbiter then emits a one-cycle trap strobe with that vector and marks the level as in service. A software level needs no grant. It is taken on the sync pulse itself and traps to a fixed vector. A return-from-interrupt strobe (debreak) retires the most urgent level in service, which lets less urgent work resume and lets arbitration restart.

Top module: `prio_intr_arb`

## Requirements
- R1: After reset, no grant is asserted, the trap strobe is low, no level is in service (`active_any` = 0) and the system is disabled.
- R2: While disabled, no new grant or software trap is issued. `sys_en_cmd` enables the system and `sys_dis_cmd` disables it; if both are given in the same cycle, the system is disabled. A grant already outstanding completes normally after a disable.
- R3: A grant or software trap begins only in the cycle that follows a clock edge at which `sync_pulse` was high. At most one grant bit is high at any time.
- R4: Among the eligible pending levels, the lowest-numbered level wins. Every hardware level (0 to 3) outranks every software level (4 to 7).
- R5: For a hardware level, `dev_grant[k]` stays high until a cycle with `dev_vec_valid` high. One cycle after that cycle, `trap_valid` is high for exactly one cycle, `trap_vec` equals the supplied vector, the grant is low, and level k is in service.
- R6: A `sw_raise[j]` strobe latches a pending request for level 4+j. When that level is selected at a sync, `trap_valid` pulses with `trap_vec` = octal 40 + j, no grant is raised, level 4+j enters service, and its pending request is cleared.
- R7: A pending level is eligible only if its number is lower than that of every level in service. An equal or less urgent request waits.
- R8: A `debreak` strobe removes only the most urgent level in service. Any less urgent levels in service stay in service.
- R9: `active_any` shows whether any level is in service. `active_lvl` gives the number of the most urgent level in service.
- R10: While a hardware grant is outstanding, no other grant or software trap is issued, even on a sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power clear) |
| sync_pulse | input | 1 | Bus sync pulse; arbitration takes place only on it |
| sys_en_cmd | input | 1 | Strobe that enables the interrupt system |
| sys_dis_cmd | input | 1 | Strobe that disables the interrupt system (wins over enable) |
| dev_req | input | 4 | Device request, one line per hardware level |
| dev_grant | output | 4 | Grant, one line per hardware level |
| dev_vec | input | 6 | Trap vector supplied by the granted device |
| dev_vec_valid | input | 1 | Qualifies `dev_vec` |
| sw_raise | input | 4 | Strobes that raise software levels 4 to 7 |
| debreak | input | 1 | Retires the most urgent level in service |
| trap_valid | output | 1 | One-cycle strobe: a trap is taken |
| trap_vec | output | 6 | Trap vector that goes with `trap_valid` |
| active_any | output | 1 | At least one level is in service |
| active_lvl | output | 3 | Number of the most urgent level in service |

## Verification
A corrupt in-service stack shows up at the ports through one of two symptoms. Either `active_lvl` reads wrong immediately, or the next sync pulse grants a level that should have been masked, or masks one that should have won. The directed cases nest up to two levels, debreak them one at a time, and re-sync after each step, so a lost or extra stack bit appears within a few cycles. A stuck grant state shows as a missing grant on the next sync pulse. A software request that is not cleared shows as a repeated trap on the next sync pulse after its debreak.

// File: rtl/prio_arb_pkg.sv
// Package: shared types for the priority interrupt arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package prio_arb_pkg;
    // Handshake state of the grant engine
    typedef enum logic {ARB_IDLE, ARB_WAIT} arb_state_e;
endpackage

// File: rtl/arb_pend.sv
// arb_pend: latches software level requests and presents the full
// pending vector (hardware levels low, software levels high).
// Assumes: sw_clr is one-hot0 and names a level being taken this cycle.
module arb_pend #(
    parameter int N_HW = 4,
    parameter int N_SW = 4,
    localparam int N_LVL = N_HW + N_SW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_HW-1:0]  dev_req,
    input  logic [N_SW-1:0]  sw_raise,
    input  logic [N_SW-1:0]  sw_clr,
    output logic [N_LVL-1:0] pend
);
    logic [N_SW-1:0] sw_pend_q;

    // Software pending bits: raise wins over clear of the same bit
    always_ff @(posedge clk) begin
        if (!rst_n) sw_pend_q <= '0;
        else        sw_pend_q <= (sw_pend_q & ~sw_clr) | sw_raise;
    end

    // Combined pending vector, level 0 at bit 0
    always_comb pend = {sw_pend_q, dev_req};

    // A cleared request drops unless raised again in the same cycle (R6)
    p_sw_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sw_clr & ~sw_raise)) |=> ((sw_pend_q & $past(sw_clr & ~sw_raise)) == '0));
endmodule

// File: rtl/arb_stack.sv
// arb_stack: in-service level stack as a bit set; the lowest set bit is
// the current level. Produces the mask of levels allowed to preempt.
// Assumes: push only names levels more urgent than the current one.
module arb_stack #(
    parameter int N_LVL = 8,
    localparam int LVL_W = $clog2(N_LVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LVL-1:0] push,
    input  logic             debreak,
    output logic [N_LVL-1:0] above_mask,
    output logic             active_any,
    output logic [LVL_W-1:0] active_lvl
);
    localparam logic [N_LVL-1:0] ONE = {{(N_LVL-1){1'b0}}, 1'b1};

    logic [N_LVL-1:0] act_q;
    logic [N_LVL-1:0] top_bit;

    // Isolate the most urgent level in service
    always_comb top_bit = act_q & (~act_q + ONE);

    // Levels strictly more urgent than the current one may preempt
    always_comb above_mask = (|act_q) ? (top_bit - ONE) : '1;

    // Encode the most urgent level in service
    always_comb begin
        active_lvl = '0;
        for (int i = N_LVL - 1; i >= 0; i--)
            if (act_q[i]) active_lvl = LVL_W'(i);
    end

    always_comb active_any = |act_q;

    // Retire the top level on debreak, then record the new level
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= (act_q & ~(debreak ? top_bit : '0)) | push;
    end

    p_push_above_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|push) |-> ((push & ~above_mask) == '0));
    p_push_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|push) |=> ((act_q & $past(push)) == $past(push)));
    p_debreak_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (debreak && (|act_q) && !(|push)) |=> ($countones(act_q) == $countones($past(act_q)) - 1));
    p_push_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push));
endmodule

// File: rtl/arb_grant.sv
// arb_grant: on a sync pulse, picks the most urgent eligible level. A
// hardware level gets a grant that is held until the device vector
// arrives; a software level traps at once with a fixed vector.
// Assumes: dev_vec_valid is only driven while a grant is outstanding.
module arb_grant
    import prio_arb_pkg::*;
#(
    parameter int N_HW = 4,
    parameter int N_SW = 4,
    parameter int VEC_W = 6,
    parameter int SW_VEC_BASE = 32,
    localparam int N_LVL = N_HW + N_SW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_pulse,
    input  logic             sys_en_cmd,
    input  logic             sys_dis_cmd,
    input  logic [N_LVL-1:0] pend,
    input  logic [N_LVL-1:0] above_mask,
    input  logic [VEC_W-1:0] dev_vec,
    input  logic             dev_vec_valid,
    output logic [N_HW-1:0]  dev_grant,
    output logic [N_LVL-1:0] push,
    output logic             trap_valid,
    output logic [VEC_W-1:0] trap_vec
);
    localparam logic [N_LVL-1:0] ONE = {{(N_LVL-1){1'b0}}, 1'b1};

    arb_state_e       state_q;
    logic             en_q;
    logic [N_HW-1:0]  grant_q;
    logic [N_LVL-1:0] elig, pick;
    logic             start, pick_sw, done_hw;
    int               pick_idx;

    // Eligible levels and the winner (lowest index)
    always_comb begin
        elig     = pend & above_mask;
        pick     = elig & (~elig + ONE);
        pick_idx = 0;
        for (int i = N_LVL - 1; i >= 0; i--)
            if (pick[i]) pick_idx = i;
        pick_sw  = |pick[N_LVL-1:N_HW];
        start    = sync_pulse && en_q && (state_q == ARB_IDLE) && (|elig);
        done_hw  = (state_q == ARB_WAIT) && dev_vec_valid;
    end

    // Level entering service this cycle
    always_comb begin
        push = '0;
        if (done_hw)             push = {{N_SW{1'b0}}, grant_q};
        else if (start && pick_sw) push = pick;
    end

    // System enable flag: disable wins
    always_ff @(posedge clk) begin
        if (!rst_n)           en_q <= 1'b0;
        else if (sys_dis_cmd) en_q <= 1'b0;
        else if (sys_en_cmd)  en_q <= 1'b1;
    end

    // Grant handshake and trap strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ARB_IDLE;
            grant_q    <= '0;
            trap_valid <= 1'b0;
            trap_vec   <= '0;
        end else begin
            trap_valid <= 1'b0;
            if (done_hw) begin
                state_q    <= ARB_IDLE;
                grant_q    <= '0;
                trap_valid <= 1'b1;
                trap_vec   <= dev_vec;
            end else if (start) begin
                if (pick_sw) begin
                    trap_valid <= 1'b1;
                    trap_vec   <= VEC_W'(SW_VEC_BASE + pick_idx - N_HW);
                end else begin
                    state_q <= ARB_WAIT;
                    grant_q <= pick[N_HW-1:0];
                end
            end
        end
    end

    always_comb dev_grant = grant_q;

    p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));
    p_grant_on_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_q) && !$past(|grant_q)) |-> $past(sync_pulse));
    p_no_grant_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !(|grant_q)) |=> !(|grant_q));
    p_grant_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_q) && !dev_vec_valid) |=> ($stable(grant_q) && !trap_valid));
endmodule

// File: rtl/prio_intr_arb.sv
// prio_intr_arb: top of the eight-level priority interrupt arbiter.
// Ties the pending latch, the grant engine and the in-service stack.
// Assumes: inputs synchronous to clk; sync_pulse one cycle wide.
module prio_intr_arb #(
    parameter int N_HW = 4,
    parameter int N_SW = 4,
    parameter int VEC_W = 6,
    parameter int SW_VEC_BASE = 32,
    localparam int N_LVL = N_HW + N_SW,
    localparam int LVL_W = $clog2(N_LVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_pulse,
    input  logic             sys_en_cmd,
    input  logic             sys_dis_cmd,
    input  logic [N_HW-1:0]  dev_req,
    output logic [N_HW-1:0]  dev_grant,
    input  logic [VEC_W-1:0] dev_vec,
    input  logic             dev_vec_valid,
    input  logic [N_SW-1:0]  sw_raise,
    input  logic             debreak,
    output logic             trap_valid,
    output logic [VEC_W-1:0] trap_vec,
    output logic             active_any,
    output logic [LVL_W-1:0] active_lvl
);
    logic [N_LVL-1:0] pend, above_mask, push;

    arb_pend #(.N_HW(N_HW), .N_SW(N_SW)) u_pend (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .sw_raise(sw_raise),
        .sw_clr(push[N_LVL-1:N_HW]), .pend(pend)
    );

    arb_grant #(.N_HW(N_HW), .N_SW(N_SW), .VEC_W(VEC_W), .SW_VEC_BASE(SW_VEC_BASE)) u_grant (
        .clk(clk), .rst_n(rst_n), .sync_pulse(sync_pulse), .sys_en_cmd(sys_en_cmd),
        .sys_dis_cmd(sys_dis_cmd), .pend(pend), .above_mask(above_mask),
        .dev_vec(dev_vec), .dev_vec_valid(dev_vec_valid), .dev_grant(dev_grant),
        .push(push), .trap_valid(trap_valid), .trap_vec(trap_vec)
    );

    arb_stack #(.N_LVL(N_LVL)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .debreak(debreak),
        .above_mask(above_mask), .active_any(active_any), .active_lvl(active_lvl)
    );
endmodule

// File: tb/tb_prio_intr_arb.sv
// Directed bench for prio_intr_arb: inputs are driven after falling
// edges, outputs are checked after the next falling edge.
module tb_prio_intr_arb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_pulse = 1'b0, sys_en_cmd = 1'b0, sys_dis_cmd = 1'b0;
    logic [3:0] dev_req = '0, sw_raise = '0;
    logic [5:0] dev_vec = '0;
    logic       dev_vec_valid = 1'b0, debreak = 1'b0;
    logic [3:0] dev_grant;
    logic       trap_valid, active_any;
    logic [5:0] trap_vec;
    logic [2:0] active_lvl;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prio_intr_arb dut (
        .clk(clk), .rst_n(rst_n), .sync_pulse(sync_pulse), .sys_en_cmd(sys_en_cmd),
        .sys_dis_cmd(sys_dis_cmd), .dev_req(dev_req), .dev_grant(dev_grant),
        .dev_vec(dev_vec), .dev_vec_valid(dev_vec_valid), .sw_raise(sw_raise),
        .debreak(debreak), .trap_valid(trap_valid), .trap_vec(trap_vec),
        .active_any(active_any), .active_lvl(active_lvl)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_sync();
        sync_pulse = 1'b1; step(1); sync_pulse = 1'b0;
    endtask

    task automatic do_debreak();
        debreak = 1'b1; step(1); debreak = 1'b0;
    endtask

    // Device answers its grant; trap strobe must last one cycle (R5)
    task automatic give_vec(input logic [5:0] v, input int lvl);
        dev_vec = v; dev_vec_valid = 1'b1; step(1); dev_vec_valid = 1'b0;
        check("R5 trap strobe", trap_valid, 1);
        check("R5 trap vector", trap_vec, v);
        check("R5 grant dropped", dev_grant, 0);
        check("R9 level in service", active_lvl, lvl);
        step(1);
        check("R5 strobe one cycle", trap_valid, 0);
    endtask

    task automatic t_reset();
        check("R1 grant", dev_grant, 0);
        check("R1 trap", trap_valid, 0);
        check("R1 none active", active_any, 0);
    endtask

    task automatic t_enable_first_grant();
        dev_req = 4'b0010;
        do_sync();
        check("R2 disabled blocks grant", dev_grant, 0);
        sys_en_cmd = 1'b1; step(1); sys_en_cmd = 1'b0;
        step(1);
        check("R3 no grant without sync", dev_grant, 0);
        do_sync();
        check("R3 grant on sync", dev_grant, 4'b0010);
        give_vec(6'o52, 1);
        dev_req = '0;
    endtask

    task automatic t_nesting();
        dev_req = 4'b0100;
        do_sync();
        check("R7 less urgent waits", dev_grant, 0);
        dev_req = 4'b0101;
        do_sync();
        check("R4 preempting level granted", dev_grant, 4'b0001);
        give_vec(6'o44, 0);
        dev_req = 4'b0100;
        do_debreak();
        check("R8 nested level resumes", active_lvl, 1);
        check("R8 still active", active_any, 1);
        do_debreak();
        check("R9 stack empty", active_any, 0);
        do_sync();
        check("R7 waiting level now granted", dev_grant, 4'b0100);
        dev_req = 4'b0101;
        do_sync();
        check("R10 grant held, no second grant", dev_grant, 4'b0100);
        give_vec(6'o61, 2);
        do_sync();
        check("R4 preempts level 2", dev_grant, 4'b0001);
        give_vec(6'o45, 0);
        dev_req = '0;
        do_debreak();
        check("R8 back to level 2", active_lvl, 2);
        do_debreak();
        check("R8 empty again", active_any, 0);
    endtask

    task automatic t_priority();
        dev_req = 4'b1010;
        do_sync();
        check("R4 lowest index wins", dev_grant, 4'b0010);
        give_vec(6'o50, 1);
        dev_req = '0;
        do_debreak();
        do_sync();
        check("R4 no stale grant", dev_grant, 0);
    endtask

    task automatic t_software();
        sw_raise = 4'b0101; step(1); sw_raise = '0;
        check("R6 no trap before sync", trap_valid, 0);
        do_sync();
        check("R6 sw trap", trap_valid, 1);
        check("R6 sw vector level 4", trap_vec, 6'o40);
        check("R6 no grant for sw", dev_grant, 0);
        check("R9 level 4 active", active_lvl, 4);
        step(1);
        check("R6 strobe one cycle", trap_valid, 0);
        do_sync();
        check("R7 level 6 waits", trap_valid, 0);
        do_debreak();
        do_sync();
        check("R6 sw trap level 6", trap_valid, 1);
        check("R6 sw vector level 6", trap_vec, 6'o42);
        check("R9 level 6 active", active_lvl, 6);
        do_debreak();
        do_sync();
        check("R6 pending cleared", trap_valid, 0);
        check("R8 empty", active_any, 0);
    endtask

    task automatic t_hw_over_sw();
        sw_raise = 4'b0010; dev_req = 4'b1000; step(1); sw_raise = '0;
        do_sync();
        check("R4 hw level 3 beats sw level 5", dev_grant, 4'b1000);
        check("R4 no sw trap", trap_valid, 0);
        give_vec(6'o77, 3);
        dev_req = '0;
        do_sync();
        check("R7 sw level 5 waits", trap_valid, 0);
        do_debreak();
        do_sync();
        check("R6 sw vector level 5", trap_vec, 6'o41);
        check("R9 level 5 active", active_lvl, 5);
        do_debreak();
    endtask

    task automatic t_enable_clash();
        sys_en_cmd = 1'b1; sys_dis_cmd = 1'b1; step(1);
        sys_en_cmd = 1'b0; sys_dis_cmd = 1'b0;
        dev_req = 4'b0001;
        do_sync();
        check("R2 disable wins", dev_grant, 0);
        sys_en_cmd = 1'b1; step(1); sys_en_cmd = 1'b0;
        do_sync();
        check("R2 re-enabled grant", dev_grant, 4'b0001);
        sys_dis_cmd = 1'b1; step(1); sys_dis_cmd = 1'b0;
        check("R2 outstanding grant kept", dev_grant, 4'b0001);
        give_vec(6'o46, 0);
        dev_req = '0;
        do_debreak();
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_enable_first_grant();
        t_nesting();
        t_priority();
        t_software();
        t_hw_over_sw();
        t_enable_clash();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule